// File: doc/BRIEF.md
# FIFO-Buffered SPI Master

This block is a memory-mapped SPI master. The host drives a single-cycle register bus with three word registers: control and status at 0x00, a data port at 0x04 and a clock divider at 0x08. A write of the data port queues one byte in a 16-entry transmit FIFO. A read of the data port pops one byte from a 16-entry receive FIFO. While the run bit is set, the shift engine takes bytes from the transmit FIFO. It exchanges each one full-duplex as an 8-bit frame, MSB first, on `sclk`, `mosi` and `miso`, and stores the received byte in the receive FIFO.

One of three chip-select lines is asserted for as long as the run bit is set. Each line has its own active level. Clock polarity and phase follow the usual four SPI modes. The `sclk` rate comes from the divider register. An interrupt output combines two flags, each with its own enable. The first says the transfer has drained. The second says the receive FIFO has reached its 12-byte service level.

A read returns data on `bus_rdata` one clock after the read strobe, and a read of the data port pops the FIFO at that same edge.

Top module: `spi_fifo_master`

## Requirements
- R1: After reset the control/status word reads 0x0004_0000 (only the TX-room flag set), all `cs_line` outputs are 1, and `sclk` and `irq` are 0.
- R2: The control word holds the chip-select index in bits [1:0], phase in bit 2, clock polarity in bit 3, the common high-active select flag in bit 6, run in bit 7, the drained-interrupt enable in bit 9, the service-interrupt enable in bit 10 and per-line high-active flags in bits [23:21], and all of these read back as written. The divider register at 0x08 reads back as written.
- R3: The TX FIFO holds 16 bytes. Bit 18 reads 1 while it has room. A data-port write when it is full is dropped.
- R4: The RX FIFO holds 16 bytes. Bit 17 reads 1 when it holds data and bit 20 reads 1 when it is full. A data-port read of an empty RX FIFO returns 0 and changes nothing.
- R5: Bit 19 reads 1 exactly when 12 or more bytes wait in the RX FIFO.
- R6: Bit 16 (drained) reads 1 when run is set, the TX FIFO is empty and no frame is in flight. Setting run with an empty TX FIFO raises it at once.
- R7: `irq` equals (drained AND bit 9) OR (service flag AND bit 10), registered one clock after the flags.
- R8: Each frame is 8 bits, MSB first, full duplex. Phase 0 samples `miso` on the leading `sclk` edge and changes `mosi` on the trailing edge. Phase 1 changes `mosi` on the leading edge and samples on the trailing edge. `sclk` rests at the polarity bit.
- R9: Within a frame each `sclk` phase lasts floor(D/2) system clocks for a divider value D of 2 or more. D = 1 behaves as 2, and D = 0 gives 32768 clocks per phase (a division of 65536).
- R10: While run is set, the line equal to the select index is at its active level and the other lines are at their inactive level. An index of 3 selects no line. Line k is high-active when bit 6 or bit 21+k is set, and low-active otherwise.
- R11: Writing 1 to bit 4 empties the TX FIFO and writing 1 to bit 5 empties the RX FIFO. Both bits read back as 0.
- R12: Clearing run stops any frame at once, returns `sclk` to the polarity level and drives every chip-select line inactive.
- R13: No new frame starts while the RX FIFO is full. It starts once a byte has been read out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the clock after a read strobe |
| irq | output | 1 | Interrupt request |
| sclk | output | 1 | SPI clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_line | output | 3 | Chip-select lines |

## Verification
The bench builds the block with its default parameters: 16-deep FIFOs, a service level of 12 and a 16-bit divider. With these values the full and threshold boundaries can be reached with a few dozen bytes. It sweeps all four clock modes against divider values 1, 2, 5 and 6, which covers the odd-value rounding and the fastest rate. One run with a divider of 0 measures a single 32768-clock phase. The chip-select output is checked against every combination of select index, common polarity and per-line polarity.

// File: rtl/spi_fifo_master_pkg.sv
package spi_fifo_master_pkg;

  localparam int CS_LINES = 3;

  // control/status bit positions
  localparam int B_CPHA     = 2;
  localparam int B_CPOL     = 3;
  localparam int B_CLR_TX   = 4;
  localparam int B_CLR_RX   = 5;
  localparam int B_POL_ALL  = 6;
  localparam int B_RUN      = 7;
  localparam int B_IE_DONE  = 9;
  localparam int B_IE_NEED  = 10;
  localparam int B_DRAINED  = 16;
  localparam int B_RX_AVAIL = 17;
  localparam int B_TX_ROOM  = 18;
  localparam int B_RX_NEED  = 19;
  localparam int B_RX_FULL  = 20;
  localparam int B_POL_LINE = 21;

  localparam logic [3:0] A_CTRL = 4'h0;
  localparam logic [3:0] A_DATA = 4'h4;
  localparam logic [3:0] A_DIV  = 4'h8;

  typedef struct packed {
    logic [CS_LINES-1:0] pol_line;
    logic                ie_need;
    logic                ie_done;
    logic                run;
    logic                pol_all;
    logic                cpol;
    logic                cpha;
    logic [1:0]          sel;
  } ctrl_t;

endpackage

// File: rtl/spi_sync_fifo.sv
module spi_sync_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         clr,
  input  logic                         push,
  input  logic [W-1:0]                 din,
  input  logic                         pop,
  output logic [W-1:0]                 dout,
  output logic                         empty,
  output logic                         full,
  output logic [$clog2(DEPTH+1)-1:0]   count
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH+1);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic             do_push, do_pop;

  assign empty   = (count == '0);
  assign full    = (count == CNT_W'(DEPTH));
  assign do_push = push & ~full;
  assign do_pop  = pop & ~empty;
  assign dout    = mem[rd_ptr];

  function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
    return (p == PTR_LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= step(wr_ptr);
      if (do_pop)  rd_ptr <= step(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    count <= CNT_W'(DEPTH));

  p_full_drop_r3: assert property (@(posedge clk) disable iff (rst)
    (push && full && !pop && !clr) |=> (count == CNT_W'(DEPTH)));

endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine #(
  parameter int FRAME_W = 8,
  parameter int DIV_W   = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               run,
  input  logic               cpol,
  input  logic               cpha,
  input  logic [DIV_W-1:0]   div,
  input  logic               tx_empty,
  input  logic [FRAME_W-1:0] tx_data,
  output logic               tx_pop,
  input  logic               rx_full,
  output logic               rx_push,
  output logic [FRAME_W-1:0] rx_data,
  input  logic               miso,
  output logic               sclk,
  output logic               mosi,
  output logic               busy
);
  localparam int EDGES = 2 * FRAME_W;
  localparam int IDX_W = $clog2(EDGES);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(EDGES - 1);

  logic [DIV_W-1:0]   half, cnt;
  logic [IDX_W-1:0]   idx;
  logic [FRAME_W-1:0] tx_sh, rx_sh;
  logic               lead, samp, shft, edge_now, start;

  // phase length: D/2 rounded down, D=1 acts as 2, D=0 is the slowest
  always_comb begin
    if (div == '0)                   half = {1'b1, {(DIV_W-1){1'b0}}};
    else if (div[DIV_W-1:1] == '0)   half = DIV_W'(1);
    else                             half = {1'b0, div[DIV_W-1:1]};
  end

  assign lead     = ~idx[0];
  assign samp     = cpha ? ~lead : lead;
  assign shft     = cpha ? lead : (~lead & (idx != IDX_LAST));
  assign edge_now = busy & (cnt == '0);
  assign start    = run & ~busy & ~tx_empty & ~rx_full;
  assign tx_pop   = start;
  assign rx_push  = run & edge_now & (idx == IDX_LAST);
  assign rx_data  = samp ? {rx_sh[FRAME_W-2:0], miso} : rx_sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      sclk  <= 1'b0;
      mosi  <= 1'b0;
      cnt   <= '0;
      idx   <= '0;
      tx_sh <= '0;
      rx_sh <= '0;
    end else if (!run) begin
      busy <= 1'b0;
      sclk <= cpol;
      cnt  <= '0;
      idx  <= '0;
    end else if (!busy) begin
      sclk <= cpol;
      if (start) begin
        busy  <= 1'b1;
        cnt   <= half - DIV_W'(1);
        idx   <= '0;
        mosi  <= tx_data[FRAME_W-1];
        tx_sh <= cpha ? tx_data : {tx_data[FRAME_W-2:0], 1'b0};
      end
    end else if (cnt != '0) begin
      cnt <= cnt - DIV_W'(1);
    end else begin
      sclk <= ~sclk;
      cnt  <= half - DIV_W'(1);
      idx  <= idx + 1'b1;
      if (shft) begin
        mosi  <= tx_sh[FRAME_W-1];
        tx_sh <= {tx_sh[FRAME_W-2:0], 1'b0};
      end
      if (samp) rx_sh <= {rx_sh[FRAME_W-2:0], miso};
      if (idx == IDX_LAST) busy <= 1'b0;
    end
  end

  p_stop_r12: assert property (@(posedge clk) disable iff (rst)
    !run |=> !busy);

  p_rx_guard_r13: assert property (@(posedge clk) disable iff (rst)
    rx_push |-> !rx_full);

endmodule

// File: rtl/spi_cs_drive.sv
module spi_cs_drive (
  input  logic clk,
  input  logic rst,
  input  logic hit,
  input  logic act_high,
  output logic line
);
  always_ff @(posedge clk) begin
    if (rst) line <= 1'b1;
    else     line <= hit ? act_high : ~act_high;
  end
endmodule

// File: rtl/spi_fifo_master.sv
module spi_fifo_master
  import spi_fifo_master_pkg::*;
#(
  parameter int DIV_W      = 16,
  parameter int FIFO_DEPTH = 16,
  parameter int NEED_LEVEL = 12,
  parameter int FRAME_W    = 8,
  parameter int ADDR_W     = 4,
  parameter int DATA_W     = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_en,
  input  logic                bus_we,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  output logic                irq,
  output logic                sclk,
  output logic                mosi,
  input  logic                miso,
  output logic [CS_LINES-1:0] cs_line
);
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

  ctrl_t            ctrl_q;
  logic [DIV_W-1:0] div_q;

  logic wr_ctrl, wr_data, wr_div, rd_any, rd_data;
  logic clr_tx, clr_rx;
  logic tx_empty, tx_full, tx_pop;
  logic rx_empty, rx_full, rx_push;
  logic [FRAME_W-1:0] tx_head, rx_head, rx_word;
  logic [CNT_W-1:0]   tx_count, rx_count;
  logic eng_busy, drained, rx_need;
  logic [DATA_W-1:0] status_word;
  logic wdata_unused, tx_count_unused;

  assign wr_ctrl = bus_en & bus_we & (bus_addr == ADDR_W'(A_CTRL));
  assign wr_data = bus_en & bus_we & (bus_addr == ADDR_W'(A_DATA));
  assign wr_div  = bus_en & bus_we & (bus_addr == ADDR_W'(A_DIV));
  assign rd_any  = bus_en & ~bus_we;
  assign rd_data = rd_any & (bus_addr == ADDR_W'(A_DATA));
  assign clr_tx  = wr_ctrl & bus_wdata[B_CLR_TX];
  assign clr_rx  = wr_ctrl & bus_wdata[B_CLR_RX];
  assign wdata_unused    = ^bus_wdata;
  assign tx_count_unused = ^tx_count;

  spi_sync_fifo #(.W(FRAME_W), .DEPTH(FIFO_DEPTH)) u_tx_fifo (
    .clk(clk), .rst(rst), .clr(clr_tx),
    .push(wr_data), .din(bus_wdata[FRAME_W-1:0]),
    .pop(tx_pop), .dout(tx_head),
    .empty(tx_empty), .full(tx_full), .count(tx_count)
  );

  spi_sync_fifo #(.W(FRAME_W), .DEPTH(FIFO_DEPTH)) u_rx_fifo (
    .clk(clk), .rst(rst), .clr(clr_rx),
    .push(rx_push), .din(rx_word),
    .pop(rd_data), .dout(rx_head),
    .empty(rx_empty), .full(rx_full), .count(rx_count)
  );

  spi_shift_engine #(.FRAME_W(FRAME_W), .DIV_W(DIV_W)) u_engine (
    .clk(clk), .rst(rst), .run(ctrl_q.run), .cpol(ctrl_q.cpol), .cpha(ctrl_q.cpha),
    .div(div_q), .tx_empty(tx_empty), .tx_data(tx_head), .tx_pop(tx_pop),
    .rx_full(rx_full), .rx_push(rx_push), .rx_data(rx_word),
    .miso(miso), .sclk(sclk), .mosi(mosi), .busy(eng_busy)
  );

  assign drained = ctrl_q.run & tx_empty & ~eng_busy;
  assign rx_need = (rx_count >= CNT_W'(NEED_LEVEL));

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else if (wr_ctrl) begin
      ctrl_q.sel      <= bus_wdata[1:0];
      ctrl_q.cpha     <= bus_wdata[B_CPHA];
      ctrl_q.cpol     <= bus_wdata[B_CPOL];
      ctrl_q.pol_all  <= bus_wdata[B_POL_ALL];
      ctrl_q.run      <= bus_wdata[B_RUN];
      ctrl_q.ie_done  <= bus_wdata[B_IE_DONE];
      ctrl_q.ie_need  <= bus_wdata[B_IE_NEED];
      ctrl_q.pol_line <= bus_wdata[B_POL_LINE +: CS_LINES];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         div_q <= '0;
    else if (wr_div) div_q <= bus_wdata[DIV_W-1:0];
  end

  always_comb begin
    status_word                        = '0;
    status_word[1:0]                   = ctrl_q.sel;
    status_word[B_CPHA]                = ctrl_q.cpha;
    status_word[B_CPOL]                = ctrl_q.cpol;
    status_word[B_POL_ALL]             = ctrl_q.pol_all;
    status_word[B_RUN]                 = ctrl_q.run;
    status_word[B_IE_DONE]             = ctrl_q.ie_done;
    status_word[B_IE_NEED]             = ctrl_q.ie_need;
    status_word[B_DRAINED]             = drained;
    status_word[B_RX_AVAIL]            = ~rx_empty;
    status_word[B_TX_ROOM]             = ~tx_full;
    status_word[B_RX_NEED]             = rx_need;
    status_word[B_RX_FULL]             = rx_full;
    status_word[B_POL_LINE +: CS_LINES] = ctrl_q.pol_line;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (rd_any) begin
      case (bus_addr)
        ADDR_W'(A_CTRL): bus_rdata <= status_word;
        ADDR_W'(A_DATA): bus_rdata <= rx_empty ? '0 : DATA_W'(rx_head);
        ADDR_W'(A_DIV):  bus_rdata <= DATA_W'(div_q);
        default:         bus_rdata <= '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= (drained & ctrl_q.ie_done) | (rx_need & ctrl_q.ie_need);
  end

  for (genvar k = 0; k < CS_LINES; k++) begin : g_cs
    spi_cs_drive u_cs (
      .clk(clk), .rst(rst),
      .hit(ctrl_q.run & (ctrl_q.sel == 2'(k))),
      .act_high(ctrl_q.pol_all | ctrl_q.pol_line[k]),
      .line(cs_line[k])
    );
  end

  p_rd_empty_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (rd_data && rx_empty) |=> (bus_rdata == '0));

  p_done_irq_r7: assert property (@(posedge clk) disable iff (rst)
    (drained && ctrl_q.ie_done) |=> irq);

endmodule

// File: tb/spi_fifo_master_bench.sv
module spi_fifo_master_bench;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst, bus_en, bus_we, irq, sclk, mosi, miso;
  logic [3:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [2:0]  cs_l;

  spi_fifo_master u_spi_fifo_master (
    .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .sclk(sclk),
    .mosi(mosi), .miso(miso), .cs_line(cs_l)
  );

  int n_chk = 0, n_err = 0, cyc = 0;
  always @(posedge clk) cyc++;

  // slave model
  int sl_f, sl_cnt, sl_ne, s_idx;
  logic s_cpol, s_cpha, s_act;
  logic [7:0] sl_rx, rb;
  logic [7:0] sl_got [0:31];
  int sl_et [0:511];

  function automatic logic [7:0] resp(int f);
    return 8'((f * 37 + 91) & 255);
  endfunction
  function automatic logic [7:0] tbyte(int i, int seed);
    return 8'((i * 53 + seed * 29 + 17) & 255);
  endfunction
  function automatic int exp_half(int d);
    if (d == 0) return 32768;
    if (d < 2) return 1;
    return d / 2;
  endfunction
  function automatic logic [31:0] ctrlw(int sel, bit cpha, bit cpol, bit pa, bit run,
                                         bit ied, bit ien, logic [2:0] pp);
    logic [31:0] w;
    w = '0; w[1:0] = 2'(sel); w[2] = cpha; w[3] = cpol; w[6] = pa;
    w[7] = run; w[9] = ied; w[10] = ien; w[23:21] = pp;
    return w;
  endfunction

  assign rb   = resp(sl_f);
  assign miso = rb[3'(7 - sl_cnt)];

  always @(sclk) begin
    if (s_idx < 3 && cs_l[s_idx] == s_act) begin
      if (sl_ne < 512) sl_et[sl_ne] = cyc;
      sl_ne++;
      if ((sclk != s_cpol) ^ s_cpha) begin
        sl_rx = {sl_rx[6:0], mosi};
        sl_cnt++;
        if (sl_cnt == 8) begin
          if (sl_f < 32) sl_got[sl_f] = sl_rx;
          sl_f++;
          sl_cnt = 0;
        end
      end
    end
  end

  task automatic slave_reset(bit cpol, bit cpha);
    sl_f = 0; sl_cnt = 0; sl_ne = 0; s_cpol = cpol; s_cpha = cpha; s_idx = 0; s_act = 1'b0;
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk); bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_en = 0; bus_we = 0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    @(negedge clk); bus_en = 1; bus_we = 0; bus_addr = a;
    @(negedge clk); bus_en = 0; d = bus_rdata;
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_irq(int lim);
    int t = 0;
    while (!irq && t < lim) begin @(negedge clk); t++; end
  endtask

  task automatic run_xfer(bit cpol, bit cpha, int div, int n, int seed);
    logic [31:0] v;
    int h;
    h = exp_half(div);
    wr(4'h0, ctrlw(0, cpha, cpol, 0, 0, 0, 0, 3'b000) | 32'h30);
    wr(4'h8, 32'(div));
    slave_reset(cpol, cpha);
    for (int i = 0; i < n; i++) wr(4'h4, 32'(tbyte(i, seed)));
    wr(4'h0, ctrlw(0, cpha, cpol, 0, 1, 1, 0, 3'b000));
    wait_irq(20000);
    chk("R6 drained irq after transfer", 32'(irq), 32'd1);
    chk("R8 frames seen by slave", 32'(sl_f), 32'(n));
    chk("R8 edge count", 32'(sl_ne), 32'(16 * n));
    for (int i = 0; i < n; i++) chk("R8 mosi byte", 32'(sl_got[i]), 32'(tbyte(i, seed)));
    for (int k = 1; k < sl_ne && k < 512; k++)
      if (k % 16 != 0) chk("R9 sclk phase length", 32'(sl_et[k] - sl_et[k-1]), 32'(h));
    wr(4'h0, ctrlw(0, cpha, cpol, 0, 0, 0, 0, 3'b000));
    for (int i = 0; i < n; i++) begin
      rd(4'h4, v);
      chk("R8 miso byte", v, 32'(resp(i)));
    end
  endtask

  initial begin
    #(190000 * 20);
    n_err++;
    $display("FAIL watchdog R1..all actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int t;
    bus_en = 0; bus_we = 0; bus_addr = '0; bus_wdata = '0;
    slave_reset(0, 0);
    s_idx = 3;
    rst = 1;
    wait_cyc(5);
    rst = 0;

    // R1 reset state
    rd(4'h0, v);
    chk("R1 status after reset", v, 32'h0004_0000);
    chk("R1 cs lines", 32'(cs_l), 32'h7);
    chk("R1 sclk", 32'(sclk), 32'd0);
    chk("R1 irq", 32'(irq), 32'd0);

    // R2 readback
    wr(4'h0, 32'h00E0_064F);
    rd(4'h0, v);
    chk("R2 control readback", v, 32'h00E4_064F);
    wr(4'h8, 32'h0000_1234);
    rd(4'h8, v);
    chk("R2 divider readback", v, 32'h0000_1234);

    // R6/R7 drained at once on empty TX
    wr(4'h0, ctrlw(0, 0, 0, 0, 1, 1, 0, 3'b000));
    wait_cyc(2);
    rd(4'h0, v);
    chk("R6 drained immediately", 32'(v[16]), 32'd1);
    chk("R7 irq with drained enable", 32'(irq), 32'd1);
    wr(4'h0, ctrlw(0, 0, 0, 0, 1, 0, 0, 3'b000));
    wait_cyc(2);
    chk("R7 irq masked", 32'(irq), 32'd0);

    // R10 exhaustive select/polarity sweep
    for (int sel = 0; sel < 4; sel++)
      for (int pa = 0; pa < 2; pa++)
        for (int pp = 0; pp < 8; pp++) begin
          logic [2:0] e;
          wr(4'h0, ctrlw(sel, 0, 0, pa[0], 1, 0, 0, 3'(pp)));
          wait_cyc(2);
          for (int k = 0; k < 3; k++) begin
            logic hi;
            hi = pa[0] | pp[k];
            e[k] = (k == sel) ? hi : ~hi;
          end
          chk("R10 chip-select levels", 32'(cs_l), 32'(e));
        end
    wr(4'h0, 32'h0);
    wait_cyc(2);
    chk("R12 lines inactive after run cleared", 32'(cs_l), 32'h7);

    // R8/R9 mode and divider sweep
    for (int m = 0; m < 4; m++) begin
      run_xfer(m[1], m[0], 1, 3, m * 4 + 0);
      run_xfer(m[1], m[0], 2, 3, m * 4 + 1);
      run_xfer(m[1], m[0], 5, 3, m * 4 + 2);
      run_xfer(m[1], m[0], 6, 3, m * 4 + 3);
    end

    // R3/R4/R5/R13 full FIFOs and stall
    wr(4'h0, 32'h30);
    wr(4'h8, 32'd2);
    slave_reset(0, 0);
    for (int i = 0; i < 17; i++) wr(4'h4, 32'(tbyte(i, 3)));
    rd(4'h0, v);
    chk("R3 no room when full", 32'(v[18]), 32'd0);
    wr(4'h0, ctrlw(0, 0, 0, 0, 1, 1, 0, 3'b000));
    wait_irq(5000);
    chk("R3 only 16 bytes sent", 32'(sl_f), 32'd16);
    chk("R3 last kept byte", 32'(sl_got[15]), 32'(tbyte(15, 3)));
    rd(4'h0, v);
    chk("R4 R5 flags with full RX", 32'(v[20:16]), 32'h1F);
    wr(4'h4, 32'h0000_00A5);
    wait_cyc(200);
    chk("R13 no frame while RX full", 32'(sl_f), 32'd16);
    rd(4'h4, v);
    chk("R4 first RX byte", v, 32'(resp(0)));
    wait_cyc(100);
    chk("R13 frame after read", 32'(sl_f), 32'd17);
    chk("R13 late byte", 32'(sl_got[16]), 32'h0000_00A5);
    wr(4'h0, 32'h0);
    for (int i = 1; i < 17; i++) begin
      rd(4'h4, v);
      chk("R4 RX order", v, 32'(resp(i)));
    end
    rd(4'h4, v);
    chk("R4 empty read returns 0", v, 32'h0);
    rd(4'h0, v);
    chk("R4 no data flag", 32'(v[17]), 32'd0);
    chk("R4 no full flag", 32'(v[20]), 32'd0);

    // R5/R7 service level at 12
    wr(4'h0, 32'h30);
    slave_reset(0, 0);
    for (int i = 0; i < 11; i++) wr(4'h4, 32'(tbyte(i, 5)));
    wr(4'h0, ctrlw(0, 0, 0, 0, 1, 0, 1, 3'b000));
    wait_cyc(400);
    chk("R5 eleven bytes sent", 32'(sl_f), 32'd11);
    rd(4'h0, v);
    chk("R5 below level", 32'(v[19]), 32'd0);
    chk("R6 drained", 32'(v[16]), 32'd1);
    chk("R7 no irq below level", 32'(irq), 32'd0);
    wr(4'h4, 32'(tbyte(11, 5)));
    wait_cyc(60);
    rd(4'h0, v);
    chk("R5 at level 12", 32'(v[19]), 32'd1);
    chk("R7 irq at level", 32'(irq), 32'd1);
    rd(4'h4, v);
    wait_cyc(2);
    rd(4'h0, v);
    chk("R5 below level after read", 32'(v[19]), 32'd0);
    chk("R7 irq drops", 32'(irq), 32'd0);
    wr(4'h0, 32'h0);

    // R11 clears
    wr(4'h0, 32'h30);
    for (int i = 0; i < 3; i++) wr(4'h4, 32'(tbyte(i, 7)));
    wr(4'h0, 32'h10);
    rd(4'h0, v);
    chk("R11 clear bits read 0", 32'(v[5:4]), 32'd0);
    chk("R11 TX room after clear", 32'(v[18]), 32'd1);
    slave_reset(0, 0);
    wr(4'h0, ctrlw(0, 0, 0, 0, 1, 1, 0, 3'b000));
    wait_cyc(3);
    chk("R11 drained after TX clear", 32'(irq), 32'd1);
    wait_cyc(50);
    chk("R11 nothing sent after TX clear", 32'(sl_f), 32'd0);
    wr(4'h0, 32'h0);
    wr(4'h4, 32'h11);
    wr(4'h4, 32'h22);
    wr(4'h0, ctrlw(0, 0, 0, 0, 1, 0, 0, 3'b000));
    wait_cyc(100);
    rd(4'h0, v);
    chk("R4 data flag", 32'(v[17]), 32'd1);
    wr(4'h0, ctrlw(0, 0, 0, 0, 1, 0, 0, 3'b000) | 32'h20);
    rd(4'h0, v);
    chk("R11 RX empty after clear", 32'(v[17]), 32'd0);
    rd(4'h4, v);
    chk("R11 RX read after clear", v, 32'h0);
    wr(4'h0, 32'h0);

    // R12 abort mid-frame with polarity 1
    wr(4'h0, ctrlw(0, 0, 1, 0, 0, 0, 0, 3'b000) | 32'h30);
    wr(4'h8, 32'd8);
    slave_reset(1, 0);
    wr(4'h4, 32'h5A);
    wr(4'h4, 32'hC3);
    wr(4'h0, ctrlw(0, 0, 1, 0, 1, 0, 0, 3'b000));
    t = 0;
    while (sl_ne < 3 && t < 1000) begin @(negedge clk); t++; end
    wr(4'h0, ctrlw(0, 0, 1, 0, 0, 0, 0, 3'b000));
    wait_cyc(2);
    chk("R12 sclk at rest", 32'(sclk), 32'd1);
    chk("R12 cs inactive", 32'(cs_l), 32'h7);
    wait_cyc(100);
    chk("R12 sclk stays at rest", 32'(sclk), 32'd1);

    // R9 divider 0
    wr(4'h0, 32'h30);
    wr(4'h8, 32'd0);
    slave_reset(0, 0);
    wr(4'h4, 32'h81);
    wr(4'h0, ctrlw(0, 0, 0, 0, 1, 0, 0, 3'b000));
    t = 0;
    while (sl_ne < 2 && t < 70000) begin @(negedge clk); t++; end
    chk("R9 divider 0 phase", 32'(sl_et[1] - sl_et[0]), 32'd32768);
    wr(4'h0, 32'h30);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule